// File: doc/BRIEF.md
# Accelerator Request Handshake Controller

This controller sits between the accelerator request channel of a scalar core and the request channel of a vector backend. For each instruction the core offers, it decides when the core sees the request accepted and when the response comes back. The response may carry an exception flag. How long the response takes depends on the instruction class.

Arithmetic instructions are accepted and answered in the same cycle the backend takes them. An instruction that is already known to be illegal is answered at once with an exception. A load or store is passed to the backend, and then the core's request is held unaccepted until the load/store unit signals completion for that direction. That completion also carries the exception status. An operation with a vector length of zero is acknowledged on the spot as a no-op, unless it is a whole-register operation. Any exception puts the controller into a flush wait, which lasts until the backend reports idle.

Top module: `ahc_top`

## Requirements
- R1: With class arithmetic (`req_class_i` = 0), no illegal flag and a nonzero `vl_i`, `req_ready_o`, `resp_valid_o` and `be_req_valid_o` are all high in the cycle where `backend_ready_i` is high, with `resp_exc_o` low.
- R2: While an arithmetic or memory request waits on a low `backend_ready_i`, `be_req_valid_o` stays high and `req_ready_o` stays low.
- R3: A request flagged by `req_illegal_i`, or carrying the reserved class 3, gets `req_ready_o`, `resp_valid_o` and `resp_exc_o` high in the same cycle, and `be_req_valid_o` stays low.
- R4: Once the backend takes a load (class 1) or store (class 2), `req_ready_o` stays low until the matching completion input (`load_done_i` or `store_done_i`) goes high. The completion for the other direction is ignored.
- R5: The memory response is raised in the cycle the matching completion arrives, and `resp_exc_o` equals `mem_exc_i` in that cycle.
- R6: When `vl_i` is zero and `req_whole_reg_i` is low, a legal request is acknowledged in the same cycle with `req_ready_o` and `resp_valid_o` high, `resp_exc_o` low and `be_req_valid_o` low.
- R7: A whole-register request (`req_whole_reg_i` high) with a zero `vl_i` follows the normal path for its class and is not treated as a no-op.
- R8: After any exception response, `req_ready_o` stays low until `backend_idle_i` is sampled high. A new request can be accepted in the cycle after that.
- R9: `seg_pending_o` is high during the completion wait of a memory operation whose `req_nfields_i` was nonzero when it was issued. It is low at all other times.
- R10: `resp_valid_o` is only ever high together with `req_ready_o`, and `resp_exc_o` is only ever high together with `resp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core offers an instruction |
| req_class_i | input | 2 | 0 arithmetic, 1 load, 2 store, 3 reserved |
| req_illegal_i | input | 1 | Decode found the instruction illegal |
| req_whole_reg_i | input | 1 | Whole-register operation |
| req_nfields_i | input | NF_W | Segment field count, zero for non-segment |
| vl_i | input | VL_W | Current vector length |
| backend_ready_i | input | 1 | Backend takes a request |
| backend_idle_i | input | 1 | Backend has drained |
| load_done_i | input | 1 | Load unit completion |
| store_done_i | input | 1 | Store unit completion |
| mem_exc_i | input | 1 | Exception status qualifying a completion |
| req_ready_o | output | 1 | Core request accepted |
| resp_valid_o | output | 1 | Response to the core |
| resp_exc_o | output | 1 | Response carries an exception |
| be_req_valid_o | output | 1 | Request offered to the backend |
| seg_pending_o | output | 1 | Segment memory operation in flight |

## Verification
The assertions assume the core keeps every request field, and the vector length, stable from the moment it raises `req_valid_i` until it sees `req_ready_o`. They also assume completion pulses appear only while a memory operation is waiting. The bench drives every request through tasks that hold all fields constant until acceptance. It raises a completion only in the waiting state, and the wrong-direction completion it injects also falls inside that state. Random class, length, field count, ready delay and completion delay are drawn inside those limits.

// File: rtl/ahc_pkg.sv
package ahc_pkg;
  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_RSVD  = 2'd3
  } req_class_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_EXC,
    ACT_NOOP,
    ACT_ARITH,
    ACT_MEM
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEM_WAIT,
    ST_FLUSH
  } state_e;
endpackage

// File: rtl/ahc_decode.sv
module ahc_decode
  import ahc_pkg::*;
#(
  parameter int unsigned VL_W = 16
) (
  input  logic            req_valid_i,
  input  logic [1:0]      req_class_i,
  input  logic            req_illegal_i,
  input  logic            req_whole_reg_i,
  input  logic [VL_W-1:0] vl_i,
  output act_e            act_o,
  output logic            is_store_o
);
  req_class_e cls;
  logic       zero_len;

  assign cls        = req_class_e'(req_class_i);
  assign zero_len   = (vl_i == '0) && !req_whole_reg_i;
  assign is_store_o = (cls == CLS_STORE);

  // illegality outranks the zero-length shortcut
  always_comb begin
    act_o = ACT_NONE;
    if (req_valid_i) begin
      if (req_illegal_i || cls == CLS_RSVD) act_o = ACT_EXC;
      else if (zero_len)                    act_o = ACT_NOOP;
      else if (cls == CLS_ARITH)            act_o = ACT_ARITH;
      else                                  act_o = ACT_MEM;
    end
  end
endmodule

// File: rtl/ahc_mem_track.sv
module ahc_mem_track #(
  parameter int unsigned NF_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            is_store_i,
  input  logic [NF_W-1:0] nfields_i,
  input  logic            in_wait_i,
  input  logic            load_done_i,
  input  logic            store_done_i,
  output logic            done_hit_o,
  output logic            seg_pending_o
);
  logic store_q;
  logic seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q <= 1'b0;
      seg_q   <= 1'b0;
    end else if (issue_i) begin
      store_q <= is_store_i;
      seg_q   <= (nfields_i != '0);
    end
  end

  assign done_hit_o    = in_wait_i && (store_q ? store_done_i : load_done_i);
  assign seg_pending_o = in_wait_i && seg_q;
endmodule

// File: rtl/ahc_fsm.sv
module ahc_fsm
  import ahc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  act_e   act_i,
  input  logic   backend_ready_i,
  input  logic   backend_idle_i,
  input  logic   done_hit_i,
  input  logic   mem_exc_i,
  output logic   issue_o,
  output logic   req_ready_o,
  output logic   resp_valid_o,
  output logic   resp_exc_o,
  output logic   be_req_valid_o,
  output state_e state_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d        = state_q;
    issue_o        = 1'b0;
    req_ready_o    = 1'b0;
    resp_valid_o   = 1'b0;
    resp_exc_o     = 1'b0;
    be_req_valid_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        unique case (act_i)
          ACT_EXC: begin
            req_ready_o  = 1'b1;
            resp_valid_o = 1'b1;
            resp_exc_o   = 1'b1;
            state_d      = ST_FLUSH;
          end
          ACT_NOOP: begin
            req_ready_o  = 1'b1;
            resp_valid_o = 1'b1;
          end
          ACT_ARITH: begin
            be_req_valid_o = 1'b1;
            req_ready_o    = backend_ready_i;
            resp_valid_o   = backend_ready_i;
          end
          ACT_MEM: begin
            be_req_valid_o = 1'b1;
            if (backend_ready_i) begin
              issue_o = 1'b1;
              state_d = ST_MEM_WAIT;
            end
          end
          default: ;
        endcase
      end
      ST_MEM_WAIT: begin
        if (done_hit_i) begin
          req_ready_o  = 1'b1;
          resp_valid_o = 1'b1;
          resp_exc_o   = mem_exc_i;
          state_d      = mem_exc_i ? ST_FLUSH : ST_IDLE;
        end
      end
      ST_FLUSH: begin
        if (backend_idle_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/ahc_top.sv
module ahc_top
  import ahc_pkg::*;
#(
  parameter int unsigned VL_W = 16,
  parameter int unsigned NF_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [1:0]      req_class_i,
  input  logic            req_illegal_i,
  input  logic            req_whole_reg_i,
  input  logic [NF_W-1:0] req_nfields_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            backend_ready_i,
  input  logic            backend_idle_i,
  input  logic            load_done_i,
  input  logic            store_done_i,
  input  logic            mem_exc_i,
  output logic            req_ready_o,
  output logic            resp_valid_o,
  output logic            resp_exc_o,
  output logic            be_req_valid_o,
  output logic            seg_pending_o
);
  act_e   act;
  state_e state;
  logic   is_store, issue, done_hit, in_wait;

  assign in_wait = (state == ST_MEM_WAIT);

  ahc_decode #(.VL_W(VL_W)) u_decode (
    .req_valid_i     (req_valid_i),
    .req_class_i     (req_class_i),
    .req_illegal_i   (req_illegal_i),
    .req_whole_reg_i (req_whole_reg_i),
    .vl_i            (vl_i),
    .act_o           (act),
    .is_store_o      (is_store)
  );

  ahc_mem_track #(.NF_W(NF_W)) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .issue_i       (issue),
    .is_store_i    (is_store),
    .nfields_i     (req_nfields_i),
    .in_wait_i     (in_wait),
    .load_done_i   (load_done_i),
    .store_done_i  (store_done_i),
    .done_hit_o    (done_hit),
    .seg_pending_o (seg_pending_o)
  );

  ahc_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .act_i           (act),
    .backend_ready_i (backend_ready_i),
    .backend_idle_i  (backend_idle_i),
    .done_hit_i      (done_hit),
    .mem_exc_i       (mem_exc_i),
    .issue_o         (issue),
    .req_ready_o     (req_ready_o),
    .resp_valid_o    (resp_valid_o),
    .resp_exc_o      (resp_exc_o),
    .be_req_valid_o  (be_req_valid_o),
    .state_o         (state)
  );
endmodule

// File: rtl/ahc_top_chk.sv
module ahc_top_chk #(
  parameter int unsigned VL_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_whole_reg_i,
  input logic [VL_W-1:0] vl_i,
  input logic            backend_ready_i,
  input logic            load_done_i,
  input logic            store_done_i,
  input logic            in_wait,
  input logic            req_ready_o,
  input logic            resp_valid_o,
  input logic            resp_exc_o,
  input logic            be_req_valid_o,
  input logic            seg_pending_o
);
  p_resp_with_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> req_ready_o);

  p_exc_with_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_exc_o |-> resp_valid_o);

  p_be_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_valid_o && !backend_ready_i && req_valid_i) |=> be_req_valid_o);

  p_noop_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_exc_o && vl_i == '0 && !req_whole_reg_i) |-> !be_req_valid_o);

  p_wait_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait && !load_done_i && !store_done_i) |-> !req_ready_o);

  p_flush_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_exc_o |=> !req_ready_o);

  p_seg_in_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_pending_o |-> (in_wait && !be_req_valid_o));
endmodule

bind ahc_top ahc_top_chk #(.VL_W(VL_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_whole_reg_i (req_whole_reg_i),
  .vl_i            (vl_i),
  .backend_ready_i (backend_ready_i),
  .load_done_i     (load_done_i),
  .store_done_i    (store_done_i),
  .in_wait         (in_wait),
  .req_ready_o     (req_ready_o),
  .resp_valid_o    (resp_valid_o),
  .resp_exc_o      (resp_exc_o),
  .be_req_valid_o  (be_req_valid_o),
  .seg_pending_o   (seg_pending_o)
);

// File: tb/tb_ahc_top.sv
module tb_ahc_top;
  localparam int VL_W = 16;
  localparam int NF_W = 3;
  localparam int K_EXC = 0, K_NOOP = 1, K_ARITH = 2, K_MEM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_illegal = 0, req_whole = 0;
  logic [1:0] req_class = 0;
  logic [NF_W-1:0] req_nf = 0;
  logic [VL_W-1:0] vl = 0;
  logic be_ready = 0, be_idle = 0, ld_done = 0, st_done = 0, mem_exc = 0;
  logic req_ready, resp_valid, resp_exc, be_valid, seg_pend;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  ahc_top #(.VL_W(VL_W), .NF_W(NF_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_class_i(req_class),
    .req_illegal_i(req_illegal), .req_whole_reg_i(req_whole), .req_nfields_i(req_nf),
    .vl_i(vl), .backend_ready_i(be_ready), .backend_idle_i(be_idle),
    .load_done_i(ld_done), .store_done_i(st_done), .mem_exc_i(mem_exc),
    .req_ready_o(req_ready), .resp_valid_o(resp_valid), .resp_exc_o(resp_exc),
    .be_req_valid_o(be_valid), .seg_pending_o(seg_pend)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(logic [1:0] cls, logic ill, logic whole, logic [VL_W-1:0] l);
    if (ill || cls == 2'd3) return K_EXC;
    if (l == '0 && !whole)  return K_NOOP;
    if (cls == 2'd0)        return K_ARITH;
    return K_MEM;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R8: block stays closed until idle, then a legal arithmetic request goes through
  task automatic flush_seq(input int hold);
    req_valid = 1; req_class = 2'd0; req_illegal = 0; req_whole = 0; vl = 16'd5;
    be_ready = 1; be_idle = 0;
    for (int i = 0; i < hold; i++) begin
      #1 chk("R8", "ready during flush", req_ready, 1'b0);
      step();
    end
    be_idle = 1;
    #1 chk("R8", "ready in idle-sample cycle", req_ready, 1'b0);
    step();
    #1 chk("R8", "ready after flush", req_ready, 1'b1);
    chk("R8", "resp after flush", resp_valid, 1'b1);
    step();
    req_valid = 0; be_ready = 0; be_idle = 0;
  endtask

  task automatic run_op(input logic [1:0] cls, input logic ill, input logic whole,
                        input logic [NF_W-1:0] nf, input logic [VL_W-1:0] l,
                        input int rdy_dly, input int done_dly, input logic exc);
    int k;
    logic want_exc;
    k = kind_of(cls, ill, whole, l);
    req_valid = 1; req_class = cls; req_illegal = ill; req_whole = whole; req_nf = nf; vl = l;
    want_exc = 0;
    if (k == K_EXC || k == K_NOOP) begin
      be_ready = 1'($urandom_range(0, 1));
      #1;
      chk(k == K_EXC ? "R3" : "R6", "ready", req_ready, 1'b1);
      chk(k == K_EXC ? "R3" : "R6", "resp", resp_valid, 1'b1);
      chk(k == K_EXC ? "R3" : "R6", "exc", resp_exc, k == K_EXC);
      chk(k == K_EXC ? "R3" : "R6", "be_valid", be_valid, 1'b0);
      want_exc = (k == K_EXC);
      step();
    end else begin
      be_ready = 0;
      for (int i = 0; i < rdy_dly; i++) begin
        #1 chk("R2", "be_valid held", be_valid, 1'b1);
        chk("R2", "ready low", req_ready, 1'b0);
        step();
      end
      be_ready = 1;
      #1 chk(whole && l == 0 ? "R7" : "R1", "be_valid", be_valid, 1'b1);
      if (k == K_ARITH) begin
        chk("R1", "ready", req_ready, 1'b1);
        chk("R1", "resp", resp_valid, 1'b1);
        chk("R1", "exc", resp_exc, 1'b0);
        step();
      end else begin
        chk("R4", "ready at issue", req_ready, 1'b0);
        step();
        be_ready = 0;
        for (int i = 0; i < done_dly; i++) begin
          if (i == 0) begin
            ld_done = (cls == 2'd2); st_done = (cls == 2'd1); mem_exc = 1;
          end
          #1 chk("R4", "ready while waiting", req_ready, 1'b0);
          chk("R4", "resp while waiting", resp_valid, 1'b0);
          chk("R9", "seg pending", seg_pend, nf != 0);
          step();
          ld_done = 0; st_done = 0; mem_exc = 0;
        end
        ld_done = (cls == 2'd1); st_done = (cls == 2'd2); mem_exc = exc;
        #1 chk("R5", "ready at done", req_ready, 1'b1);
        chk("R5", "resp at done", resp_valid, 1'b1);
        chk("R5", "exc at done", resp_exc, exc);
        step();
        ld_done = 0; st_done = 0; mem_exc = 0;
        #1 chk("R9", "seg cleared", seg_pend, 1'b0);
        want_exc = exc;
      end
    end
    req_valid = 0; be_ready = 0;
    if (want_exc) flush_seq(1 + ($urandom % 3));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 chk("R10", "reset resp", resp_valid, 1'b0);
    chk("R10", "reset ready", req_ready, 1'b0);
    chk("R9", "reset seg", seg_pend, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // back-to-back arithmetic, then load that stalls, then arithmetic
    run_op(2'd0, 0, 0, 0, 16'd8, 0, 0, 0);
    run_op(2'd0, 0, 0, 0, 16'd3, 0, 0, 0);
    run_op(2'd1, 0, 0, 3'd2, 16'd4, 1, 3, 0);
    run_op(2'd0, 0, 0, 0, 16'd4, 2, 0, 0);
    // directed corners
    run_op(2'd2, 0, 0, 0, 16'd1, 0, 2, 1);
    run_op(2'd0, 1, 0, 0, 16'd9, 0, 0, 0);
    run_op(2'd3, 0, 0, 0, 16'd9, 0, 0, 0);
    run_op(2'd1, 0, 0, 0, 16'd0, 0, 0, 0);
    run_op(2'd2, 0, 1, 0, 16'd0, 1, 1, 0);
    run_op(2'd0, 0, 1, 0, 16'd0, 0, 0, 0);
    run_op(2'd1, 1, 0, 0, 16'd0, 0, 0, 0);
    for (int n = 0; n < 300; n++) begin
      run_op(2'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0, NF_W'($urandom),
             ($urandom % 5) == 0 ? 16'd0 : 16'($urandom_range(1, 64)),
             $urandom % 3, 1 + ($urandom % 4), ($urandom % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule